// File: doc/BRIEF.md
# Cross-Connect Table Update Arbiter

This block owns a small table that records, for every pairing of output port and channel, which input port currently drives it and whether that connection is live. Four ingress engines update the table. Each engine has two independent request paths: one carries connection setups and releases, the other carries updates caused by connection timeouts. The block picks one request per clock, decides whether the update may be applied, writes the table, and answers the chosen requester in the same cycle with an acknowledge pulse and a grant bit.

The table enforces exclusive ownership: a setup to an entry that is already live is refused, while any update that clears the live bit is always accepted. Engines are served in rotating order so that none can be locked out, and within one engine a pending setup or release goes ahead of a pending timeout update. A timeout-path update also raises a per-engine cause flag for the interrupt logic elsewhere. An asynchronous-free combinational read port lets the table be inspected at any address.

Top module: `xconn_table_arbiter`

## Requirements
- R1: After reset every table entry reads back as 3'b000 (not live) and no acknowledge is asserted.
- R2: A table address is {output port[1:0], channel minus one[2:0]} and a table word is {input port[1:0], live}, with the live flag in bit 0; after a granted update the read port returns the written word at that address in the following cycle (e.g. input 0 to output 3, channel 6: address 5'b11101, word 3'b001).
- R3: A request is acknowledged combinationally in the cycle it is served; at most one acknowledge (over both paths of all engines) is high in any cycle, and an acknowledge or grant is only ever given to a path whose request is high.
- R4: An update whose live bit (bit 0) is 0 is always granted and written, whether or not the entry is live.
- R5: An update whose live bit is 1 addressed to an entry that is not live is granted and written.
- R6: An update whose live bit is 1 addressed to an entry that is already live is acknowledged with grant low, and the entry keeps its previous word.
- R7: When an engine has both a setup/release request and a timeout request pending, the setup/release request is served first.
- R8: The timeout cause flag of an engine is high exactly in the cycle its timeout-path update is acknowledged.
- R9: Engines with pending requests are served one per cycle in rotating order starting after the engine served last (engine 0 first after reset), so a pending engine waits at most three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setupReq | input | 4 | Setup/release request, one bit per engine, held until acknowledged |
| setupAddr | input | 20 | Table address per engine for the setup/release path, engine e at bits [5e+4:5e] |
| setupData | input | 12 | Table word per engine for the setup/release path, engine e at bits [3e+2:3e] |
| toReq | input | 4 | Timeout-path request, one bit per engine, held until acknowledged |
| toAddr | input | 20 | Table address per engine for the timeout path |
| toData | input | 12 | Table word per engine for the timeout path |
| rdAddr | input | 5 | Inspection read address |
| setupAck | output | 4 | One-cycle acknowledge of the setup/release path per engine |
| toAck | output | 4 | One-cycle acknowledge of the timeout path per engine |
| grant | output | 4 | Per engine, 1 when the acknowledged update was applied |
| timeoutCause | output | 4 | Per engine timeout cause flag |
| rdData | output | 3 | Table word at rdAddr |

## Verification
The assertions rely on each requester holding its request, address and word steady from assertion until the cycle its acknowledge is seen, and dropping the request right after that edge; the bounded-wait check in particular assumes requests are never withdrawn early. The bench issues new requests only on idle paths just after a clock edge and clears exactly the acknowledged path after the next edge, so every random and directed sequence stays inside that contract while still mixing collisions on the same entry, paired setup and timeout requests on one engine, and all four engines contending at once.

// File: rtl/xconn_pkg.sv
package xconn_pkg;

  // Field widths of a table entry and its address
  localparam int PORT_W    = 2;
  localparam int CHAN_W    = 3;
  localparam int ADDR_W    = PORT_W + CHAN_W;
  localparam int DATA_W    = PORT_W + 1;
  localparam int TBL_DEPTH = 1 << ADDR_W;

  // Strobe bundle passed from the control to the table datapath
  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
  } tblWrT;

endpackage

// File: rtl/xconn_table_dp.sv
module xconn_table_dp
  import xconn_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tblWrT             wrCmd,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              lkLive,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] tblMem [TBL_DEPTH];

  // Table storage: cleared on reset, one write per cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_DEPTH; i++) begin
        tblMem[i] <= '0;
      end
    end else if (wrCmd.wrEn) begin
      tblMem[wrCmd.wrAddr] <= wrCmd.wrData;
    end
  end

  // Ownership lookup for the request being arbitrated
  assign lkLive = tblMem[lkAddr][0];

  // Inspection port
  assign rdData = tblMem[rdAddr];

endmodule

// File: rtl/xconn_arb_ctrl.sv
module xconn_arb_ctrl
  import xconn_pkg::*;
#(
  parameter int NUM_ENG = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_ENG-1:0]        setupReq,
  input  logic [NUM_ENG*ADDR_W-1:0] setupAddr,
  input  logic [NUM_ENG*DATA_W-1:0] setupData,
  input  logic [NUM_ENG-1:0]        toReq,
  input  logic [NUM_ENG*ADDR_W-1:0] toAddr,
  input  logic [NUM_ENG*DATA_W-1:0] toData,
  input  logic                      lkLive,
  output logic [ADDR_W-1:0]         lkAddr,
  output tblWrT                     wrCmd,
  output logic [NUM_ENG-1:0]        setupAck,
  output logic [NUM_ENG-1:0]        toAck,
  output logic [NUM_ENG-1:0]        grant,
  output logic [NUM_ENG-1:0]        timeoutCause
);

  localparam int ENG_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;

  logic [ADDR_W-1:0] sAddr [NUM_ENG];
  logic [ADDR_W-1:0] tAddr [NUM_ENG];
  logic [DATA_W-1:0] sData [NUM_ENG];
  logic [DATA_W-1:0] tData [NUM_ENG];

  // Unpack the flat per-engine buses
  for (genvar gE = 0; gE < NUM_ENG; gE++) begin : gUnpack
    assign sAddr[gE] = setupAddr[gE*ADDR_W +: ADDR_W];
    assign tAddr[gE] = toAddr[gE*ADDR_W +: ADDR_W];
    assign sData[gE] = setupData[gE*DATA_W +: DATA_W];
    assign tData[gE] = toData[gE*DATA_W +: DATA_W];
  end

  logic [NUM_ENG-1:0] pend;
  logic [ENG_W-1:0]   rrPtr;
  logic [ENG_W-1:0]   selIdx;
  logic               selFound;
  logic               useSetup;
  logic [ADDR_W-1:0]  selAddr;
  logic [DATA_W-1:0]  selData;
  logic               allow;

  assign pend = setupReq | toReq;

  // Rotating pick: first pending engine after the one served last
  always_comb begin
    selFound = 1'b0;
    selIdx   = '0;
    for (int off = 1; off <= NUM_ENG; off++) begin
      if (!selFound && pend[(int'(rrPtr) + off) % NUM_ENG]) begin
        selFound = 1'b1;
        selIdx   = ENG_W'((int'(rrPtr) + off) % NUM_ENG);
      end
    end
  end

  // Within the chosen engine the setup/release path wins
  always_comb begin
    useSetup = setupReq[selIdx];
    selAddr  = useSetup ? sAddr[selIdx] : tAddr[selIdx];
    selData  = useSetup ? sData[selIdx] : tData[selIdx];
  end

  assign lkAddr = selAddr;

  // Clearing updates always pass; setting requires a free entry
  assign allow = !selData[0] || !lkLive;

  always_comb begin
    wrCmd.wrEn   = selFound && allow;
    wrCmd.wrAddr = selAddr;
    wrCmd.wrData = selData;
  end

  always_comb begin
    setupAck = '0;
    toAck    = '0;
    grant    = '0;
    if (selFound) begin
      if (useSetup) begin
        setupAck[selIdx] = 1'b1;
      end else begin
        toAck[selIdx] = 1'b1;
      end
      grant[selIdx] = allow;
    end
  end

  assign timeoutCause = toAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= ENG_W'(NUM_ENG - 1);
    end else if (selFound) begin
      rrPtr <= selIdx;
    end
  end

endmodule

// File: rtl/xconn_table_arbiter.sv
module xconn_table_arbiter
  import xconn_pkg::*;
#(
  parameter int NUM_ENG = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_ENG-1:0]        setupReq,
  input  logic [NUM_ENG*ADDR_W-1:0] setupAddr,
  input  logic [NUM_ENG*DATA_W-1:0] setupData,
  input  logic [NUM_ENG-1:0]        toReq,
  input  logic [NUM_ENG*ADDR_W-1:0] toAddr,
  input  logic [NUM_ENG*DATA_W-1:0] toData,
  input  logic [ADDR_W-1:0]         rdAddr,
  output logic [NUM_ENG-1:0]        setupAck,
  output logic [NUM_ENG-1:0]        toAck,
  output logic [NUM_ENG-1:0]        grant,
  output logic [NUM_ENG-1:0]        timeoutCause,
  output logic [DATA_W-1:0]         rdData
);

  tblWrT             wrCmd;
  logic [ADDR_W-1:0] lkAddr;
  logic              lkLive;

  xconn_arb_ctrl #(.NUM_ENG(NUM_ENG)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .setupReq     (setupReq),
    .setupAddr    (setupAddr),
    .setupData    (setupData),
    .toReq        (toReq),
    .toAddr       (toAddr),
    .toData       (toData),
    .lkLive       (lkLive),
    .lkAddr       (lkAddr),
    .wrCmd        (wrCmd),
    .setupAck     (setupAck),
    .toAck        (toAck),
    .grant        (grant),
    .timeoutCause (timeoutCause)
  );

  xconn_table_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wrCmd  (wrCmd),
    .lkAddr (lkAddr),
    .rdAddr (rdAddr),
    .lkLive (lkLive),
    .rdData (rdData)
  );

endmodule

// File: rtl/xconn_table_arbiter_chk.sv
module xconn_table_arbiter_chk
  import xconn_pkg::*;
#(
  parameter int NUM_ENG = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_ENG-1:0]        setupReq,
  input logic [NUM_ENG*DATA_W-1:0] setupData,
  input logic [NUM_ENG-1:0]        toReq,
  input logic [NUM_ENG-1:0]        setupAck,
  input logic [NUM_ENG-1:0]        toAck,
  input logic [NUM_ENG-1:0]        grant,
  input logic [NUM_ENG-1:0]        timeoutCause
);

  assert_one_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({setupAck, toAck}))
    else $error("more than one acknowledge in a cycle");

  for (genvar e = 0; e < NUM_ENG; e++) begin : gEng
    int waitCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        waitCnt <= 0;
      end else if (setupAck[e] || toAck[e]) begin
        waitCnt <= 0;
      end else if (setupReq[e] || toReq[e]) begin
        waitCnt <= waitCnt + 1;
      end
    end

    assert_ack_has_req_R3: assert property (@(posedge clk) disable iff (!rstN)
      (setupAck[e] |-> setupReq[e]) and (toAck[e] |-> toReq[e]))
      else $error("acknowledge without request");

    assert_grant_with_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
      grant[e] |-> (setupAck[e] || toAck[e]))
      else $error("grant outside acknowledge");

    assert_release_granted_R4: assert property (@(posedge clk) disable iff (!rstN)
      (setupAck[e] && !setupData[e*DATA_W]) |-> grant[e])
      else $error("release refused");

    assert_setup_first_R7: assert property (@(posedge clk) disable iff (!rstN)
      toAck[e] |-> !setupReq[e])
      else $error("timeout served ahead of setup");

    assert_cause_on_timeout_R8: assert property (@(posedge clk) disable iff (!rstN)
      timeoutCause[e] |-> toReq[e])
      else $error("cause flag without timeout request");

    assert_no_starve_R9: assert property (@(posedge clk) disable iff (!rstN)
      waitCnt < NUM_ENG)
      else $error("engine waited too long");
  end

endmodule

bind xconn_table_arbiter xconn_table_arbiter_chk #(.NUM_ENG(NUM_ENG)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .setupReq     (setupReq),
  .setupData    (setupData),
  .toReq        (toReq),
  .setupAck     (setupAck),
  .toAck        (toAck),
  .grant        (grant),
  .timeoutCause (timeoutCause)
);

// File: tb/xconn_table_arbiter_tb.sv
module xconn_table_arbiter_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  setupReq, toReq;
  logic [19:0] setupAddr, toAddr;
  logic [11:0] setupData, toData;
  logic [4:0]  rdAddr;
  logic [3:0]  setupAck, toAck, grant, timeoutCause;
  logic [2:0]  rdData;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [2:0] expTbl [32];
  int expPtr;

  always #10 clk = ~clk;

  xconn_table_arbiter u_dut (
    .clk(clk), .rstN(rstN),
    .setupReq(setupReq), .setupAddr(setupAddr), .setupData(setupData),
    .toReq(toReq), .toAddr(toAddr), .toData(toData),
    .rdAddr(rdAddr),
    .setupAck(setupAck), .toAck(toAck), .grant(grant),
    .timeoutCause(timeoutCause), .rdData(rdData)
  );

  task automatic checkEq(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Next engine by rotation after the one served last (R9)
  function automatic int pickNext(logic [3:0] pend, int ptr);
    for (int off = 1; off <= 4; off++) begin
      if (pend[(ptr + off) % 4]) return (ptr + off) % 4;
    end
    return -1;
  endfunction

  task automatic issueSetup(int e, logic [4:0] a, logic [2:0] d);
    setupReq[e] = 1'b1;
    setupAddr[e*5 +: 5] = a;
    setupData[e*3 +: 3] = d;
  endtask

  task automatic issueTimeout(int e, logic [4:0] a, logic [2:0] d);
    toReq[e] = 1'b1;
    toAddr[e*5 +: 5] = a;
    toData[e*3 +: 3] = d;
  endtask

  // One cycle: check at the falling edge, update the model at the rising edge
  task automatic step();
    int sel;
    bit useS;
    logic [4:0] a;
    logic [2:0] d;
    bit g;
    logic [3:0] eS, eT, eG;
    string gTag;
    string aTag;
    @(negedge clk);
    sel = pickNext(setupReq | toReq, expPtr);
    eS = '0; eT = '0; eG = '0; g = 0; useS = 0; a = '0; d = '0;
    gTag = "R4";
    aTag = ($countones(setupReq | toReq) > 1) ? "R9" : "R3";
    if (sel >= 0) begin
      useS = setupReq[sel];
      a = useS ? setupAddr[sel*5 +: 5] : toAddr[sel*5 +: 5];
      d = useS ? setupData[sel*3 +: 3] : toData[sel*3 +: 3];
      g = !d[0] || !expTbl[a][0];
      if (d[0]) gTag = expTbl[a][0] ? "R6" : "R5";
      if (useS) eS[sel] = 1'b1; else eT[sel] = 1'b1;
      eG[sel] = g;
    end
    checkEq(aTag, {4'h0, setupAck}, {4'h0, eS});
    checkEq("R7", {4'h0, toAck}, {4'h0, eT});
    checkEq(gTag, {4'h0, grant}, {4'h0, eG});
    checkEq("R8", {4'h0, timeoutCause}, {4'h0, eT});
    checkEq("R2", {5'h0, rdData}, {5'h0, expTbl[rdAddr]});
    @(posedge clk);
    if (sel >= 0) begin
      if (g) expTbl[a] = d;
      expPtr = sel;
    end
    #1;
    if (sel >= 0) begin
      if (useS) setupReq[sel] = 1'b0; else toReq[sel] = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    rstN = 1'b0;
    setupReq = '0; toReq = '0;
    setupAddr = '0; toAddr = '0; setupData = '0; toData = '0;
    rdAddr = '0;
    for (int i = 0; i < 32; i++) expTbl[i] = '0;
    expPtr = 3;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: table empty, no acknowledges
    for (int i = 0; i < 32; i++) begin
      rdAddr = 5'(i);
      #1 checkEq("R1", {5'h0, rdData}, 8'h00);
    end
    checkEq("R1", {setupAck, toAck}, 8'h00);
    @(posedge clk); #1;

    // R2/R5: input 0 to output 3, channel 6
    issueSetup(0, 5'b11101, 3'b001);
    rdAddr = 5'b11101;
    step();
    @(negedge clk);
    checkEq("R2", {5'h0, rdData}, 8'h01);
    @(posedge clk); #1;

    // R6: second owner refused, entry unchanged
    issueSetup(1, 5'b11101, 3'b011);
    step();
    @(negedge clk);
    checkEq("R6", {5'h0, rdData}, 8'h01);
    @(posedge clk); #1;

    // R4: release of a live entry, then of a free one
    issueSetup(2, 5'b11101, 3'b000);
    step();
    issueSetup(2, 5'b00010, 3'b110);
    step();
    @(negedge clk);
    checkEq("R4", {5'h0, rdData}, 8'h00);
    @(posedge clk); #1;

    // R7/R8: both paths of engine 3 at once
    issueSetup(3, 5'b01000, 3'b101);
    issueTimeout(3, 5'b00111, 3'b010);
    rdAddr = 5'b01000;
    step();
    step();

    // R9: all four engines contend
    for (int e = 0; e < 4; e++) issueSetup(e, 5'(16 + e), {2'(e), 1'b1});
    for (int k = 0; k < 4; k++) step();

    // Random traffic
    for (int cyc = 0; cyc < 3000; cyc++) begin
      for (int e = 0; e < 4; e++) begin
        if (!setupReq[e] && ($urandom % 4 == 0))
          issueSetup(e, 5'($urandom), {2'($urandom), 1'($urandom % 3 != 0)});
        if (!toReq[e] && ($urandom % 6 == 0))
          issueTimeout(e, 5'($urandom), {2'($urandom), 1'($urandom % 5 == 0)});
      end
      rdAddr = 5'($urandom);
      step();
    end
    while (|(setupReq | toReq)) step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule